// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which parts of a small microcontroller core receive a clock. It holds a four-bit sleep word. One bit halts the core. The other three stop the slow crystal oscillator, the fast tunable oscillator and the subsystem clock. From these bits, and from two source selects, it drives registered enables for:

- the CPU,
- the main clock,
- the subsystem clock,
- the auxiliary clock,
- both oscillators.

An oscillator that a running clock still draws from stays on, whatever its stop bit says.

When an interrupt is accepted, the block pushes the sleep word onto a small register stack. It then clears the halt, slow-oscillator and subsystem-clock bits, so the handler can run. The fast-oscillator stop bit is kept as it was. While the handler runs, it may rewrite the saved word. A return pops that word, so the core resumes either the mode it left or the mode the handler chose. When every bit is set (the deepest sleep), only the external wake input can bring the core back.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the sleep word is 0000, the stack is empty and all six enables are 1.
- R2: The sleep word bit positions are [0] core halt, [1] slow oscillator stop, [2] fast oscillator stop and [3] subsystem clock stop. A write pulse loads the word only while bit 0 is clear. While bit 0 is set, the write is ignored.
- R3: The CPU enable and the main clock enable both equal NOT bit 0. The subsystem clock enable equals NOT bit 3. The auxiliary clock enable equals NOT bit 1.
- R4: The fast oscillator enable is 1 in any of these cases:
  - bit 2 is clear;
  - the main clock runs with main_sel=0;
  - the subsystem clock runs with sub_sel=0.

  A source select of 0 picks the fast oscillator and 1 picks the slow one.
- R5: The slow oscillator enable is 1 in any of these cases:
  - bit 1 is clear;
  - the main clock runs with main_sel=1;
  - the subsystem clock runs with sub_sel=1.
- R6: The enables are registered on the falling clock edge. They follow a change of the sleep word half a cycle after the rising edge that made it.
- R7: Interrupt entry pushes the current word, clears bits 0, 1 and 3, and leaves bit 2 unchanged. Entry is taken on irq_req or wake_ext while the stack is not full.
- R8: When all four bits are set, irq_req is ignored and the word holds. wake_ext still triggers entry.
- R9: A return pulse, while bit 0 is clear and the stack is not empty, pops the top saved word into the sleep word. With an empty stack the pulse has no effect.
- R10: A saved-word write, while the core runs and the stack is not empty, replaces the top saved word. A later return restores the replacement.
- R11: Entries nest up to DEPTH levels. Returns unwind them in reverse order. While the stack is full, an entry request is ignored.
- R12: In a single cycle a return wins over entry, and entry wins over a sleep word write. The word pushed on entry is the word from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; state on rising edge, enables on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sr_wr_en | input | 1 | Sleep word write pulse from the core |
| sr_wr_data | input | 4 | New sleep word |
| main_sel | input | 1 | Main clock source: 0 fast, 1 slow oscillator |
| sub_sel | input | 1 | Subsystem clock source: 0 fast, 1 slow oscillator |
| irq_req | input | 1 | Enabled maskable interrupt request |
| wake_ext | input | 1 | External reset/non-maskable wake request |
| reti | input | 1 | Return-from-handler pulse |
| sav_wr_en | input | 1 | Handler write of the top saved word |
| sav_wr_data | input | 4 | Replacement saved word |
| mode_bits | output | 4 | Current sleep word |
| cpu_en | output | 1 | CPU run enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Subsystem clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| fast_osc_en | output | 1 | Fast oscillator enable |
| slow_osc_en | output | 1 | Slow crystal oscillator enable |

## Verification
A corrupted sleep word shows on mode_bits at the next rising edge. It reaches the enable outputs half a cycle later, so the sweep catches it within one cycle of the faulty step. A wrong stack entry or count stays hidden until a return, where the restored word differs from the one the bench pushed. A depth error shows only when nesting reaches the limit or unwinds past it. For these reasons the bench sweeps every word under every source select through a full entry and return, and separately fills the stack to its limit and unwinds it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int MODE_W = 4;
    localparam int B_HALT = 0;
    localparam int B_SLOW = 1;
    localparam int B_FAST = 2;
    localparam int B_SUB  = 3;

    typedef logic [MODE_W-1:0] mode_t;

    // bits that survive interrupt entry
    localparam mode_t ENTRY_KEEP = mode_t'(1) << B_FAST;

    typedef struct packed {
        logic cpu;
        logic mclk;
        logic smclk;
        logic aclk;
        logic fast;
        logic slow;
    } gate_t;
endpackage

// File: rtl/pmc_save_stack.sv
module pmc_save_stack
    import pmc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  mode_t push_data,
    input  logic  pop,
    input  logic  mod_en,
    input  mode_t mod_data,
    output mode_t top_data,
    output logic  full,
    output logic  empty
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][MODE_W-1:0] ent;
        logic [CW-1:0]                cnt;
    } stk_t;

    stk_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        full     = (st_q.cnt == CW'(DEPTH));
        empty    = (st_q.cnt == '0);
        top_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i + 1) == st_q.cnt) top_data = st_q.ent[i];
        end
        if (pop && !empty) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == st_q.cnt) st_d.ent[i] = push_data;
            end
            st_d.cnt = st_q.cnt + CW'(1);
        end else if (mod_en && !empty) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i + 1) == st_q.cnt) st_d.ent[i] = mod_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/pmc_gate_decode.sv
module pmc_gate_decode
    import pmc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  main_sel,
    input  logic  sub_sel,
    output gate_t gates
);
    gate_t gate_d, gate_q;

    always_comb begin
        gate_d.cpu   = !mode[B_HALT];
        gate_d.mclk  = !mode[B_HALT];
        gate_d.smclk = !mode[B_SUB];
        gate_d.aclk  = !mode[B_SLOW];
        gate_d.fast  = !mode[B_FAST]
                     || (gate_d.mclk  && !main_sel)
                     || (gate_d.smclk && !sub_sel);
        gate_d.slow  = !mode[B_SLOW]
                     || (gate_d.mclk  && main_sel)
                     || (gate_d.smclk && sub_sel);
    end

    // enables move only while clk is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '1;
        else        gate_q <= gate_d;
    end

    assign gates = gate_q;

    // R3
    core_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gates.cpu == !mode[B_HALT]) && (gates.mclk == gates.cpu));

    // R3
    aux_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gates.aclk == !mode[B_SLOW]);

    // R4
    fast_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[B_FAST] || (!mode[B_HALT] && !main_sel)) |-> gates.fast);

    // R5
    slow_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[B_SLOW] || (!mode[B_SUB] && sub_sel)) |-> gates.slow);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sr_wr_en,
    input  logic [3:0] sr_wr_data,
    input  logic       main_sel,
    input  logic       sub_sel,
    input  logic       irq_req,
    input  logic       wake_ext,
    input  logic       reti,
    input  logic       sav_wr_en,
    input  logic [3:0] sav_wr_data,
    output logic [3:0] mode_bits,
    output logic       cpu_en,
    output logic       mclk_en,
    output logic       smclk_en,
    output logic       aclk_en,
    output logic       fast_osc_en,
    output logic       slow_osc_en
);
    typedef struct packed {
        mode_t bits;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    mode_t stk_top;
    logic  stk_full, stk_empty;
    logic  halted, deep_sleep;
    logic  pop_go, push_go, wr_go, mod_go;
    gate_t gates;

    always_comb begin
        ctl_d      = ctl_q;
        halted     = ctl_q.bits[B_HALT];
        deep_sleep = &ctl_q.bits;
        pop_go     = reti && !halted && !stk_empty;
        push_go    = !pop_go && !stk_full
                   && ((irq_req && !deep_sleep) || wake_ext);
        wr_go      = !pop_go && !push_go && sr_wr_en && !halted;
        mod_go     = !pop_go && !push_go && sav_wr_en && !halted;
        if (pop_go)       ctl_d.bits = stk_top;
        else if (push_go) ctl_d.bits = ctl_q.bits & ENTRY_KEEP;
        else if (wr_go)   ctl_d.bits = sr_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pmc_save_stack #(.DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_go),
        .push_data (ctl_q.bits),
        .pop       (pop_go),
        .mod_en    (mod_go),
        .mod_data  (sav_wr_data),
        .top_data  (stk_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    pmc_gate_decode u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (ctl_q.bits),
        .main_sel (main_sel),
        .sub_sel  (sub_sel),
        .gates    (gates)
    );

    assign mode_bits   = ctl_q.bits;
    assign cpu_en      = gates.cpu;
    assign mclk_en     = gates.mclk;
    assign smclk_en    = gates.smclk;
    assign aclk_en     = gates.aclk;
    assign fast_osc_en = gates.fast;
    assign slow_osc_en = gates.slow;

    // R7
    entry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_go |=> (mode_bits[B_HALT] == 1'b0) && (mode_bits[B_SLOW] == 1'b0)
                 && (mode_bits[B_SUB] == 1'b0)
                 && (mode_bits[B_FAST] == $past(mode_bits[B_FAST])));

    // R9
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_go |=> mode_bits == $past(stk_top));

    // R8
    deep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&mode_bits) && !wake_ext) |=> $stable(mode_bits));

    // R2
    halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bits[B_HALT] && !push_go) |=> $stable(mode_bits));
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sr_wr_en = 1'b0;
    logic [3:0] sr_wr_data = '0;
    logic       main_sel = 1'b0;
    logic       sub_sel = 1'b0;
    logic       irq_req = 1'b0;
    logic       wake_ext = 1'b0;
    logic       reti = 1'b0;
    logic       sav_wr_en = 1'b0;
    logic [3:0] sav_wr_data = '0;
    logic [3:0] mode_bits;
    logic       cpu_en, mclk_en, smclk_en, aclk_en, fast_osc_en, slow_osc_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sr_wr_en(sr_wr_en), .sr_wr_data(sr_wr_data),
        .main_sel(main_sel), .sub_sel(sub_sel), .irq_req(irq_req),
        .wake_ext(wake_ext), .reti(reti), .sav_wr_en(sav_wr_en),
        .sav_wr_data(sav_wr_data), .mode_bits(mode_bits), .cpu_en(cpu_en),
        .mclk_en(mclk_en), .smclk_en(smclk_en), .aclk_en(aclk_en),
        .fast_osc_en(fast_osc_en), .slow_osc_en(slow_osc_en)
    );

    function automatic logic [5:0] exp_en(logic [3:0] b, logic ms, logic ss);
        logic c, s, a, f, w;
        c = !b[0]; s = !b[3]; a = !b[1];
        f = !b[2] || (c && !ms) || (s && !ss);
        w = !b[1] || (c && ms) || (s && ss);
        return {c, c, s, a, f, w};
    endfunction

    function automatic logic [5:0] got_en();
        return {cpu_en, mclk_en, smclk_en, aclk_en, fast_osc_en, slow_osc_en};
    endfunction

    task automatic chk(string req, logic [5:0] got, logic [5:0] expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s got=%b exp=%b t=%0t", req, got, expv, $time);
        end
    endtask

    // rising edge, release one-cycle pulses
    task automatic tick();
        @(posedge clk); #1;
        sr_wr_en = 0; irq_req = 0; wake_ext = 0; reti = 0; sav_wr_en = 0;
    endtask

    // wait until enables have been updated on the falling edge
    task automatic settle();
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1;
        settle();
    endtask

    task automatic wr(logic [3:0] v);
        sr_wr_en = 1; sr_wr_data = v; tick(); settle();
    endtask

    task automatic irq();  irq_req = 1;  tick(); settle(); endtask
    task automatic wake(); wake_ext = 1; tick(); settle(); endtask
    task automatic ret();  reti = 1;     tick(); settle(); endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 mode", {2'b0, mode_bits}, 6'b0);
        chk("R1 enables", got_en(), 6'b111111);
        ret();
        chk("R9 empty return ignored", {2'b0, mode_bits}, 6'b0);

        // sweep every word under every source select
        for (int v = 0; v < 16; v++) begin
            for (int s = 0; s < 4; s++) begin
                logic [3:0] w, e;
                w = 4'(v);
                do_reset();
                main_sel = s[0]; sub_sel = s[1];
                settle();
                wr(w);
                chk("R2 write", {2'b0, mode_bits}, {2'b0, w});
                chk("R3/R4/R5 enables", got_en(), exp_en(w, s[0], s[1]));
                if (w[0]) begin
                    wr(4'b0000);
                    chk("R2 halted write ignored", {2'b0, mode_bits}, {2'b0, w});
                end
                if (w == 4'b1111) begin
                    irq();
                    chk("R8 irq ignored in deep sleep", {2'b0, mode_bits}, 6'b001111);
                    wake();
                end else begin
                    irq();
                end
                e = w & 4'b0100;
                chk("R7 entry word", {2'b0, mode_bits}, {2'b0, e});
                chk("R7 entry enables", got_en(), exp_en(e, s[0], s[1]));
                ret();
                chk("R9 restore", {2'b0, mode_bits}, {2'b0, w});
                chk("R9 restore enables", got_en(), exp_en(w, s[0], s[1]));
            end
        end

        // R6: enables lag the word by half a cycle
        do_reset();
        main_sel = 0; sub_sel = 0;
        sr_wr_en = 1; sr_wr_data = 4'b0001; tick();
        chk("R6 word at rising edge", {2'b0, mode_bits}, 6'b000001);
        chk("R6 cpu_en still high", {5'b0, cpu_en}, 6'b000001);
        settle();
        chk("R6 cpu_en after falling edge", {5'b0, cpu_en}, 6'b0);

        // R10: handler rewrites the saved word
        do_reset();
        wr(4'b1101);
        irq();
        sav_wr_en = 1; sav_wr_data = 4'b0001; tick(); settle();
        chk("R10 word unchanged by saved write", {2'b0, mode_bits}, 6'b000100);
        ret();
        chk("R10 return to rewritten mode", {2'b0, mode_bits}, 6'b000001);
        chk("R10 enables", got_en(), exp_en(4'b0001, 1'b0, 1'b0));

        // R11: nesting to the limit and unwinding
        do_reset();
        irq();
        wr(4'b1000);
        irq();
        wr(4'b0010);
        irq();
        chk("R11 entry ignored when full", {2'b0, mode_bits}, 6'b000010);
        ret();
        chk("R11 first unwind", {2'b0, mode_bits}, 6'b001000);
        ret();
        chk("R11 second unwind", {2'b0, mode_bits}, 6'b000000);

        // R12: priorities within one cycle
        do_reset();
        wr(4'b1000);
        irq_req = 1; sr_wr_en = 1; sr_wr_data = 4'b0010; tick(); settle();
        chk("R12 entry beats write", {2'b0, mode_bits}, 6'b000000);
        reti = 1; irq_req = 1; tick(); settle();
        chk("R12 return beats entry", {2'b0, mode_bits}, 6'b001000);
        ret();
        chk("R12 stack empty after return", {2'b0, mode_bits}, 6'b001000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule